// File: doc/BRIEF.md
# Invalidation Acknowledgement Write-Completion Tracker

This block sits next to a processor's cache controller in a directory-based shared-memory multiprocessor. It decides when a store has finished. When the processor's write goes out, the block is told how many invalidation messages were sent for it. It then counts the acknowledgements that come back from the network, in any order and with any gaps between them. The write counts as complete only when the last acknowledgement has arrived. The block marks that moment with a one-cycle pulse.

While a write is unfinished, the block stalls the processor's next access, so each processor's accesses complete in program order. A read is also tracked, and it is complete once its data comes back. Until the write completes, the block also holds back any remote read of the address being written, so no reader sees the new value while stale copies may remain. Remote reads of other addresses are never held. An acknowledgement that arrives when no write is pending sets a sticky error flag and changes nothing else.

Top module: `wr_ack_tracker`

## Requirements
- R1: After synchronous reset, `busy`, `write_done`, `ack_err`, `acc_stall` and `rmt_hold` are all 0.
- R2: An accepted write with invalidation count N>0 raises `busy` in the cycle after issue. `busy` stays high until the Nth acknowledgement. In the cycle after the edge that takes the Nth acknowledgement, `write_done` is 1 for exactly one cycle and `busy` is 0.
- R3: An accepted write with count 0 gives a `write_done` pulse in the cycle after issue, and `busy` stays 0.
- R4: At most one acknowledgement arrives per cycle, and idle cycles may fall between acknowledgements. Each acknowledgement lowers the outstanding count by one, so after N-1 acknowledgements `busy` is still 1 and `write_done` is 0.
- R5: An acknowledgement taken while `busy` is 0 sets `ack_err`, which stays 1 until reset. Such an acknowledgement is not counted against the next write.
- R6: `acc_stall` is 1 whenever a write is pending or a local read is outstanding. A write issue or read request presented while `acc_stall` is 1 is ignored: it neither reloads the count nor starts a read.
- R7: A local read request accepted while `acc_stall` is 0 (and with no write issue in the same cycle, because a write takes priority) raises `acc_stall` from the next cycle. `acc_stall` drops in the cycle after the edge that takes `rd_resp`.
- R8: `rmt_hold` is 1 in the same cycle as a remote read request whose address equals the pending write's address while `busy` is 1. It is 0 for any other address, and it is 0 once the write has completed.
- R9: `write_done` is never 1 in a cycle where `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_issue | input | 1 | Processor issues a write this cycle |
| wr_addr | input | ADDR_W | Address of the issued write |
| wr_inv_cnt | input | CNT_W | Number of invalidations sent for the write |
| ack_valid | input | 1 | One invalidation acknowledgement arrives |
| lcl_rd_req | input | 1 | Processor issues a read this cycle |
| rd_resp | input | 1 | Return data for the outstanding read has arrived |
| rmt_rd_req | input | 1 | A reader asks for a line |
| rmt_rd_addr | input | ADDR_W | Address of that read |
| busy | output | 1 | A write is waiting for acknowledgements |
| write_done | output | 1 | One-cycle completion pulse |
| ack_err | output | 1 | Sticky flag for an unexpected acknowledgement |
| acc_stall | output | 1 | Processor must not issue its next access |
| rmt_hold | output | 1 | The presented read must wait for the pending write |

## Verification
Every state result (`busy`, `write_done`, `ack_err`, `acc_stall`) is due one cycle after the clock edge that takes its stimulus. `rmt_hold` is a decode of the current request against held state, so it is due in the same cycle. The bench drives inputs just after a rising edge and reads state outputs just after the next rising edge. It probes `rmt_hold` after a short settle delay inside the same cycle. Acknowledgement sequences have idle gaps, and the check of the pulse width reads `write_done` on the following edge as well.

// File: rtl/wat_pkg.sv
package wat_pkg;
  parameter int unsigned DEF_CNT_W  = 6;
  parameter int unsigned DEF_ADDR_W = 16;
endpackage

// File: rtl/ack_counter.sv
module ack_counter #(
  parameter int unsigned CNT_W = wat_pkg::DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_cnt,
  input  logic             ack,
  output logic             busy,
  output logic             done,
  output logic             err
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
      err   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (ack && !busy) err <= 1'b1;
      if (load) begin
        if (load_cnt == '0) begin
          done <= 1'b1;
        end else begin
          cnt_q <= load_cnt;
          busy  <= 1'b1;
        end
      end else if (ack && busy) begin
        cnt_q <= cnt_q - ONE;
        if (cnt_q == ONE) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  a_r4_count_down: assert property (@(posedge clk) disable iff (rst)
    (busy && ack && !load) |=> (cnt_q == $past(cnt_q) - ONE));
  a_r5_err_sticky: assert property (@(posedge clk) disable iff (rst)
    err |=> err);
  a_r2_fall_with_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
endmodule

// File: rtl/order_gate.sv
module order_gate (
  input  logic clk,
  input  logic rst,
  input  logic wr_issue,
  input  logic rd_req,
  input  logic rd_resp,
  input  logic wr_busy,
  output logic wr_acc,
  output logic stall
);
  logic rd_out_q;
  logic rd_acc;

  assign stall  = wr_busy | rd_out_q;
  assign wr_acc = wr_issue & ~stall;
  assign rd_acc = rd_req & ~wr_issue & ~stall;

  always_ff @(posedge clk) begin
    if (rst)             rd_out_q <= 1'b0;
    else if (rd_acc)     rd_out_q <= 1'b1;
    else if (rd_resp)    rd_out_q <= 1'b0;
  end

  a_r7_read_releases: assert property (@(posedge clk) disable iff (rst)
    (rd_out_q && rd_resp && !wr_busy) |=> !stall);
  a_r6_no_accept_in_stall: assert property (@(posedge clk) disable iff (rst)
    stall |-> !(wr_acc || rd_acc));
endmodule

// File: rtl/vis_gate.sv
module vis_gate #(
  parameter int unsigned ADDR_W = wat_pkg::DEF_ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [ADDR_W-1:0] cap_addr,
  input  logic              pending,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              hold
);
  logic [ADDR_W-1:0] pend_addr_q;

  always_ff @(posedge clk) begin
    if (rst)          pend_addr_q <= '0;
    else if (capture) pend_addr_q <= cap_addr;
  end

  assign hold = pending & rd_req & (rd_addr == pend_addr_q);
endmodule

// File: rtl/wr_ack_tracker.sv
module wr_ack_tracker #(
  parameter int unsigned CNT_W  = wat_pkg::DEF_CNT_W,
  parameter int unsigned ADDR_W = wat_pkg::DEF_ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_issue,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_inv_cnt,
  input  logic              ack_valid,
  input  logic              lcl_rd_req,
  input  logic              rd_resp,
  input  logic              rmt_rd_req,
  input  logic [ADDR_W-1:0] rmt_rd_addr,
  output logic              busy,
  output logic              write_done,
  output logic              ack_err,
  output logic              acc_stall,
  output logic              rmt_hold
);
  logic wr_acc;

  order_gate u_order (
    .clk(clk), .rst(rst), .wr_issue(wr_issue), .rd_req(lcl_rd_req),
    .rd_resp(rd_resp), .wr_busy(busy), .wr_acc(wr_acc), .stall(acc_stall)
  );

  ack_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .load(wr_acc), .load_cnt(wr_inv_cnt),
    .ack(ack_valid), .busy(busy), .done(write_done), .err(ack_err)
  );

  vis_gate #(.ADDR_W(ADDR_W)) u_vis (
    .clk(clk), .rst(rst), .capture(wr_acc), .cap_addr(wr_addr),
    .pending(busy), .rd_req(rmt_rd_req), .rd_addr(rmt_rd_addr), .hold(rmt_hold)
  );

  a_r9_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    write_done |-> !busy);
  a_r6_busy_stalls: assert property (@(posedge clk) disable iff (rst)
    busy |-> acc_stall);
endmodule

// File: tb/sim_wr_ack_tracker.sv
`timescale 1ns/1ps
module sim_wr_ack_tracker;
  localparam int CW = 6;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_issue = 0, ack_valid = 0, lcl_rd_req = 0, rd_resp = 0, rmt_rd_req = 0;
  logic [AW-1:0] wr_addr = '0, rmt_rd_addr = '0;
  logic [CW-1:0] wr_inv_cnt = '0;
  logic busy, write_done, ack_err, acc_stall, rmt_hold;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  wr_ack_tracker #(.CNT_W(CW), .ADDR_W(AW)) u0 (.*);

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [AW-1:0] a, input logic [CW-1:0] n);
    wr_issue = 1; wr_addr = a; wr_inv_cnt = n;
    step();
    wr_issue = 0;
  endtask

  task automatic one_ack();
    ack_valid = 1; step(); ack_valid = 0;
  endtask

  task automatic t_reset();
    rst = 1; step(); step(); rst = 0;
    chk("R1", "busy", busy, 0);
    chk("R1", "write_done", write_done, 0);
    chk("R1", "ack_err", ack_err, 0);
    chk("R1", "acc_stall", acc_stall, 0);
    chk("R1", "rmt_hold", rmt_hold, 0);
  endtask

  task automatic t_multi_ack();
    issue(16'h1234, 3);
    chk("R2", "busy after issue", busy, 1);
    chk("R6", "stall while busy", acc_stall, 1);
    rmt_rd_req = 1; rmt_rd_addr = 16'h1234; #0.5;
    chk("R8", "hold same addr", rmt_hold, 1);
    rmt_rd_addr = 16'h1235; #0.5;
    chk("R8", "hold other addr", rmt_hold, 0);
    rmt_rd_req = 0;
    one_ack(); step();
    one_ack(); step(); step();
    chk("R4", "busy after N-1", busy, 1);
    chk("R4", "done after N-1", write_done, 0);
    one_ack();
    chk("R2", "done pulse", write_done, 1);
    chk("R2", "busy cleared", busy, 0);
    step();
    chk("R2", "pulse one cycle", write_done, 0);
    rmt_rd_req = 1; rmt_rd_addr = 16'h1234; #0.5;
    chk("R8", "hold after done", rmt_hold, 0);
    rmt_rd_req = 0;
  endtask

  task automatic t_zero();
    issue(16'h0042, 0);
    chk("R3", "done for zero", write_done, 1);
    chk("R3", "busy for zero", busy, 0);
    step();
    chk("R3", "pulse ends", write_done, 0);
  endtask

  task automatic t_stray_ack();
    one_ack();
    chk("R5", "err set", ack_err, 1);
    issue(16'h0007, 2);
    one_ack();
    chk("R5", "stray not counted", busy, 1);
    one_ack();
    chk("R5", "done after own acks", write_done, 1);
    step();
    chk("R5", "err sticky", ack_err, 1);
  endtask

  task automatic t_ignore_issue();
    issue(16'h0100, 2);
    issue(16'h0200, 5);
    rmt_rd_req = 1; rmt_rd_addr = 16'h0200; #0.5;
    chk("R6", "addr not replaced", rmt_hold, 0);
    rmt_rd_req = 0;
    one_ack(); one_ack();
    chk("R6", "count not reloaded", write_done, 1);
    chk("R6", "busy low", busy, 0);
  endtask

  task automatic t_read();
    step();
    lcl_rd_req = 1; step(); lcl_rd_req = 0;
    chk("R7", "stall on read", acc_stall, 1);
    issue(16'h0300, 4);
    chk("R6", "write ignored in read", busy, 0);
    step();
    chk("R7", "stall held", acc_stall, 1);
    rd_resp = 1; step(); rd_resp = 0;
    chk("R7", "stall released", acc_stall, 0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_multi_ack();
        t_zero();
        t_stray_ack();
        t_ignore_issue();
        t_read();
        t_reset();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule